// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point value into a 32-bit single-precision word. The value arrives as a class code, a sign, an unbiased signed exponent, a wide mantissa whose top bit is an explicit leading one, and a sticky bit that summarises any bits already discarded upstream. A two-bit mode input selects how the value is rounded. The block aligns the mantissa with its own right shifter, folds every bit shifted out into the sticky bit, rounds, and then assembles the word.

The result comes with four flags: inexact, underflow, overflow and operand error. Special classes pass through without flags: zero, infinity, and NaN, whose upper payload bits are kept. The number path covers three cases. Tiny values are denormalised, and rounding may carry them into the smallest normal. A rounding carry can bump the exponent. Results that are too large saturate to infinity or to the largest finite value, depending on the mode and the sign.

The block is a two-stage pipeline. Stage one decodes the value and aligns the mantissa. Stage two rounds the mantissa and registers the packed word. It accepts one value per cycle.

Top module: `sp_packer`

## Requirements
- R1: A value presented with `in_valid` high appears on the outputs, with `out_valid` high, exactly two rising edges later. Back-to-back inputs give back-to-back results, and results stay in order. After reset, `out_valid`, `out_word` and all four flags are zero.
- R2: The class field is encoded as 0 = zero, 1 = number, 2 = infinity, 3 = NaN. A zero packs as the sign in bit 31 with all other bits clear. An infinity packs as the sign, exponent field (bits 30:23) all ones, and fraction (bits 22:0) zero. Neither raises any flag.
- R3: A NaN packs as the sign, exponent field all ones, and a fraction equal to the 23 mantissa bits directly below the leading one (`in_mant[MANT_W-2 -: 23]`). It raises no flag.
- R4: For a number whose exponent plus 127 is at least 1, the exponent field is that sum. The fraction is the 23 mantissa bits below the leading one, rounded using all lower bits and `in_sticky`. Mode encoding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity. Inexact is set when any discarded bit or `in_sticky` is nonzero.
- R5: When rounding a normal value carries out of the fraction, the exponent field increases by one and the fraction becomes zero.
- R6: When the final biased exponent is 255 or more, overflow, inexact and operand error are all set and underflow is clear. The word is a signed infinity in mode 0, in mode 3 for a positive value, and in mode 2 for a negative value. In every other case it is the largest finite magnitude: exponent field 254, fraction all ones. Operand error is never set without overflow.
- R7: When the exponent plus 127 is 0 or less, underflow is always set. The leading one and the upper mantissa bits shift into the fraction, behind as many leading zeros as the exponent falls short. The exponent field is 0 unless R8 applies.
- R8: When subnormal rounding carries into the bit above the fraction, the word is the smallest normal: exponent field 1 and fraction 0. Underflow is still set.
- R9: A shift that moves the whole mantissa below the round position leaves a zero fraction, with sticky equal to the OR of the mantissa and `in_sticky`. A positive value then rounds to `0x00000001` in mode 3 and to `0x00000000` in modes 0 and 1. Inexact and underflow are set in each case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value is present this cycle |
| in_class | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, explicit leading one at the top bit |
| in_sticky | input | 1 | OR of bits already discarded upstream |
| rnd_mode | input | 2 | Rounding mode: 0 nearest-even, 1 to zero, 2 to minus inf, 3 to plus inf |
| out_valid | output | 1 | Result is present this cycle |
| out_word | output | 32 | Packed single-precision word |
| flag_inexact | output | 1 | Result differs from the exact value |
| flag_underflow | output | 1 | Subnormal path was taken |
| flag_overflow | output | 1 | Exponent exceeded the finite range |
| flag_operr | output | 1 | Operand error, raised together with overflow |

## Verification
The assertions assume that every value of class 1 has the top mantissa bit set, and one of them checks this at the input. They also assume that `in_valid` is low while reset is asserted. The random stimulus always forces that top bit to one for class 1 values. Reset is held with `in_valid` low. Exponents are drawn from the full signed range, with extra weight near the overflow edge, the subnormal edge and the region where the mantissa is shifted out entirely. Tie patterns are forced often enough that round-to-even is exercised in every mode.

// File: rtl/sp_packer.sv
module sp_packer #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  input  logic [1:0]              rnd_mode,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic                    flag_inexact,
  output logic                    flag_underflow,
  output logic                    flag_overflow,
  output logic                    flag_operr
);
  localparam int FRAC_W  = 23;
  localparam int KEEP_W  = FRAC_W + 3;
  localparam int BASE_SH = MANT_W - KEEP_W;
  localparam int EB_W    = EXP_W + 2;
  localparam int SH_W    = EB_W + 1;
  localparam int SHC_W   = $clog2(MANT_W);

  localparam logic [1:0] C_ZERO = 2'd0;
  localparam logic [1:0] C_NUM  = 2'd1;
  localparam logic [1:0] C_INF  = 2'd2;
  localparam logic [1:0] M_NEAR = 2'd0;
  localparam logic [1:0] M_ZERO = 2'd1;
  localparam logic [1:0] M_DOWN = 2'd2;

  // stage 1: bias, pick shift, align with sticky collection
  logic signed [EB_W-1:0] exp_ext, ebias_c;
  logic                   sub_c, sh_big, lost_c;
  logic [SH_W-1:0]        sh_c;
  logic [SHC_W-1:0]       sh_amt;
  logic [KEEP_W-1:0]      keep_c;

  assign exp_ext = {{2{in_exp[EXP_W-1]}}, in_exp};
  assign ebias_c = exp_ext + $signed(EB_W'(127));
  assign sub_c   = (ebias_c <= $signed(EB_W'(0)));
  assign sh_c    = sub_c ? (SH_W'(BASE_SH + 1) - {ebias_c[EB_W-1], ebias_c}) : SH_W'(BASE_SH);
  assign sh_big  = (sh_c >= SH_W'(MANT_W));
  assign sh_amt  = SHC_W'(sh_c);
  assign keep_c  = sh_big ? '0 : KEEP_W'(in_mant >> sh_amt);
  assign lost_c  = sh_big ? (|in_mant) : (|(in_mant & ~({MANT_W{1'b1}} << sh_amt)));

  logic                   v1, sign1, sub1, stk1;
  logic [1:0]             cls1, mode1;
  logic signed [EB_W-1:0] ebias1;
  logic [KEEP_W-1:0]      keep1;
  logic [FRAC_W-1:0]      nan1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      sign1  <= 1'b0;
      sub1   <= 1'b0;
      stk1   <= 1'b0;
      cls1   <= C_ZERO;
      mode1  <= M_NEAR;
      ebias1 <= '0;
      keep1  <= '0;
      nan1   <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        sign1  <= in_sign;
        sub1   <= sub_c;
        stk1   <= in_sticky | lost_c;
        cls1   <= in_class;
        mode1  <= rnd_mode;
        ebias1 <= ebias_c;
        keep1  <= keep_c;
        nan1   <= in_mant[MANT_W-2 -: FRAC_W];
      end
    end
  end

  // stage 2: round and pack
  logic                   g_bit, r_bit, lsb, inexact_raw, rnd_up, ovf, to_inf;
  logic [FRAC_W+1:0]      sum;
  logic signed [EB_W-1:0] e_fin;
  logic [31:0]            word_c;
  logic [3:0]             flags_c;

  assign g_bit       = keep1[1];
  assign r_bit       = keep1[0];
  assign lsb         = keep1[2];
  assign inexact_raw = g_bit | r_bit | stk1;

  always_comb begin
    case (mode1)
      M_NEAR:  rnd_up = g_bit & (r_bit | stk1 | lsb);
      M_ZERO:  rnd_up = 1'b0;
      M_DOWN:  rnd_up = sign1 & inexact_raw;
      default: rnd_up = ~sign1 & inexact_raw;
    endcase
  end

  assign sum    = {1'b0, keep1[KEEP_W-1:2]} + (FRAC_W+2)'(rnd_up);
  assign e_fin  = ebias1 + $signed({{(EB_W-1){1'b0}}, sum[FRAC_W+1]});
  assign ovf    = ~sub1 & (e_fin >= $signed(EB_W'(255)));
  assign to_inf = (mode1 == M_NEAR) || (mode1 == M_DOWN && sign1) || (mode1 == 2'd3 && !sign1);

  always_comb begin
    word_c  = {sign1, 31'd0};
    flags_c = 4'b0000;
    case (cls1)
      C_ZERO: word_c = {sign1, 31'd0};
      C_INF:  word_c = {sign1, 8'hFF, 23'd0};
      C_NUM: begin
        if (sub1) begin
          word_c  = {sign1, 7'd0, sum[FRAC_W], sum[FRAC_W-1:0]};
          flags_c = {inexact_raw, 1'b1, 1'b0, 1'b0};
        end else if (ovf) begin
          word_c  = to_inf ? {sign1, 8'hFF, 23'd0} : {sign1, 8'hFE, 23'h7FFFFF};
          flags_c = 4'b1011;
        end else begin
          word_c  = {sign1, e_fin[7:0], sum[FRAC_W-1:0]};
          flags_c = {inexact_raw, 3'b000};
        end
      end
      default: word_c = {sign1, 8'hFF, nan1};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_word       <= '0;
      flag_inexact   <= 1'b0;
      flag_underflow <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_operr     <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_word <= word_c;
        {flag_inexact, flag_underflow, flag_overflow, flag_operr} <= flags_c;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  p_no_phantom_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  p_lead_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == C_NUM) |-> in_mant[MANT_W-1]);
  p_special_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[30:23] == 8'hFF && !flag_overflow) |-> (!flag_inexact && !flag_underflow && !flag_operr));
  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |-> (flag_inexact && flag_operr && !flag_underflow && out_word[30:23] >= 8'hFE));
  p_operr_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_operr) |-> flag_overflow);
  p_unf_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_underflow) |-> (out_word[30:24] == 7'd0));
  p_min_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_underflow && out_word[23]) |-> (out_word[22:0] == 23'd0));
endmodule

// File: tb/sp_packer_tb.sv
module sp_packer_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_class = 2'd0;
  logic              in_sign = 1'b0;
  logic signed [9:0] in_exp = '0;
  logic [31:0]       in_mant = '0;
  logic              in_sticky = 1'b0;
  logic [1:0]        rnd_mode = 2'd0;
  logic              out_valid;
  logic [31:0]       out_word;
  logic              flag_inexact, flag_underflow, flag_overflow, flag_operr;

  sp_packer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .out_word(out_word),
    .flag_inexact(flag_inexact), .flag_underflow(flag_underflow),
    .flag_overflow(flag_overflow), .flag_operr(flag_operr)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, wr = 0, rd = 0;
  bit done = 0;
  logic [35:0] exp_q [0:8191];
  int          iss_q [0:8191];
  string       tag_q [0:8191];

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // {word, inexact, underflow, overflow, operr}
  function automatic logic [35:0] model(input logic [1:0] c, input logic s, input int e,
                                        input logic [31:0] m, input logic st, input logic [1:0] md);
    longint unsigned q, rem, half;
    int el, d, be;
    bit inx, up, gt, tie;
    if (c == 2'd0) return {s, 31'd0, 4'b0};
    if (c == 2'd2) return {s, 8'hFF, 23'd0, 4'b0};
    if (c == 2'd3) return {s, 8'hFF, m[30:8], 4'b0};
    el = (e < -126) ? -126 : e;
    d  = 8 + (el - e);
    if (d >= 40) begin
      q = 0; rem = m; gt = 0; tie = 0;
    end else begin
      q    = longint'(m) >> d;
      rem  = longint'(m) & ((64'd1 << d) - 1);
      half = 64'd1 << (d - 1);
      gt   = (rem > half) || (rem == half && st);
      tie  = (rem == half) && !st;
    end
    inx = (rem != 0) || st;
    case (md)
      2'd0: up = gt || (tie && q[0]);
      2'd1: up = 0;
      2'd2: up = s && inx;
      default: up = !s && inx;
    endcase
    q = q + up;
    if (e >= -126) begin
      be = e + 127;
      if (q >= 64'd16777216) begin be++; q = q >> 1; end
      if (be >= 255) begin
        if (md == 0 || (md == 3 && !s) || (md == 2 && s)) return {s, 8'hFF, 23'd0, 4'b1011};
        return {s, 8'hFE, 23'h7FFFFF, 4'b1011};
      end
      return {s, 8'(be), q[22:0], inx, 3'b000};
    end
    be = (q >= 64'd8388608) ? 1 : 0;
    return {s, 8'(be), q[22:0], inx, 3'b100};
  endfunction

  task automatic observe();
    if (out_valid) begin
      if (rd >= wr) begin
        chk(0, "R1 unexpected output", {out_word, 4'b0}, '0);
      end else begin
        chk({out_word, flag_inexact, flag_underflow, flag_overflow, flag_operr} == exp_q[rd],
            tag_q[rd], {out_word, flag_inexact, flag_underflow, flag_overflow, flag_operr}, exp_q[rd]);
        chk(cyc - iss_q[rd] == 2, "R1 latency", 36'(cyc - iss_q[rd]), 36'd2);
        rd++;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cyc++;
    observe();
    in_valid = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c, input logic s, input int e, input logic [31:0] m,
                       input logic st, input logic [1:0] md, input string tag);
    @(negedge clk);
    cyc++;
    observe();
    in_valid = 1'b1; in_class = c; in_sign = s; in_exp = 10'(e);
    in_mant = m; in_sticky = st; rnd_mode = md;
    exp_q[wr] = model(c, s, e, m, st, md);
    iss_q[wr] = cyc;
    tag_q[wr] = tag;
    wr++;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog R1 actual=%0d expected=<150000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] m;
    int e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({out_valid, out_word, flag_inexact, flag_underflow, flag_overflow, flag_operr} == 37'd0,
        "R1 reset state", {out_word, 4'b0}, '0);
    rst_n = 1'b1;
    idle();

    issue(2'd0, 1'b0, 0, 32'h0, 1'b0, 2'd0, "R2 +zero");
    issue(2'd0, 1'b1, 5, 32'h0, 1'b1, 2'd3, "R2 -zero");
    issue(2'd2, 1'b1, 0, 32'h0, 1'b0, 2'd0, "R2 -inf");
    issue(2'd3, 1'b0, 0, 32'hC0001234, 1'b0, 2'd1, "R3 nan payload");
    issue(2'd3, 1'b1, 0, 32'hFFFFFFFF, 1'b1, 2'd0, "R3 nan full");
    issue(2'd1, 1'b0, 0, 32'h80000000, 1'b0, 2'd0, "R4 one exact");
    issue(2'd1, 1'b0, 3, 32'h80000080, 1'b0, 2'd0, "R4 tie even down");
    issue(2'd1, 1'b0, 3, 32'h80000180, 1'b0, 2'd0, "R4 tie odd up");
    issue(2'd1, 1'b0, 3, 32'h80000080, 1'b1, 2'd0, "R4 tie sticky up");
    issue(2'd1, 1'b1, 3, 32'h80000001, 1'b0, 2'd2, "R4 down neg");
    issue(2'd1, 1'b0, 3, 32'h80000001, 1'b0, 2'd3, "R4 up pos");
    issue(2'd1, 1'b0, 3, 32'h800000FF, 1'b0, 2'd1, "R4 trunc");
    issue(2'd1, 1'b0, 10, 32'hFFFFFF80, 1'b0, 2'd0, "R5 carry exp");
    issue(2'd1, 1'b0, 127, 32'hFFFFFF80, 1'b0, 2'd0, "R6 carry to inf");
    issue(2'd1, 1'b0, 127, 32'hFFFFFF80, 1'b0, 2'd1, "R6 to max");
    issue(2'd1, 1'b1, 200, 32'h80000000, 1'b0, 2'd3, "R6 neg up max");
    issue(2'd1, 1'b1, 200, 32'h80000000, 1'b0, 2'd2, "R6 neg down inf");
    issue(2'd1, 1'b0, -130, 32'hA5A5A5A5, 1'b0, 2'd0, "R7 subnormal");
    issue(2'd1, 1'b0, -127, 32'h80000000, 1'b0, 2'd0, "R7 exact sub");
    issue(2'd1, 1'b0, -127, 32'hFFFFFFFF, 1'b0, 2'd0, "R8 to min normal");
    issue(2'd1, 1'b1, -127, 32'hFFFFFF00, 1'b0, 2'd2, "R8 neg min normal");
    issue(2'd1, 1'b0, -400, 32'h80000000, 1'b0, 2'd3, "R9 far up");
    issue(2'd1, 1'b0, -400, 32'h80000000, 1'b0, 2'd0, "R9 far near");
    issue(2'd1, 1'b0, -512, 32'h80000000, 1'b0, 2'd1, "R9 far zero");
    issue(2'd1, 1'b0, -150, 32'h80000000, 1'b0, 2'd0, "R9 half tie");
    repeat (3) idle();

    for (int i = 0; i < 4000; i++) begin
      int k, cs;
      logic [1:0] c;
      k = int'($urandom_range(0, 9));
      case (k)
        4: e = int'($urandom_range(0, 40)) - 160;
        5: e = int'($urandom_range(0, 15)) + 120;
        6: e = int'($urandom_range(0, 1023)) - 512;
        7: e = int'($urandom_range(0, 10)) - 155;
        default: e = int'($urandom_range(0, 253)) - 126;
      endcase
      m = {1'b1, 31'($urandom)};
      if ($urandom_range(0, 3) == 0) m[7:0] = 8'h80;
      cs = int'($urandom_range(0, 15));
      c = (cs == 0) ? 2'd0 : (cs == 1) ? 2'd2 : (cs == 2) ? 2'd3 : 2'd1;
      issue(c, 1'($urandom), e, m, ($urandom_range(0, 3) == 0), 2'($urandom),
            (e < -126) ? "R7 random sub" : (e > 120) ? "R6 random high" : "R4 random");
      if ($urandom_range(0, 7) == 0) idle();
    end
    repeat (4) idle();
    chk(rd == wr, "R1 all results returned", 36'(rd), 36'(wr));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule